// File: doc/BRIEF.md
# Four-Level Interrupt Priority Controller

This block sits between six interrupt sources and a CPU core and reduces them to a single vectored request. The sources are two external requests, three timers and one serial source. The serial source is the OR of a receive flag, a transmit flag and a synchronous-serial flag. The third timer's source is the OR of its overflow flag and its external-event flag. Each source has its own enable bit, and one global enable bit gates them all. Each source has a two-bit priority level, formed from one bit taken from each of two priority registers.

The controller keeps a four-bit in-service mask, with one bit for each priority level, so that it can decide on nesting. A pending source may be granted only when its level is strictly above every level that is in service. Among the eligible sources the highest level wins, and a tie within a level goes to the source that comes first in the fixed order. The request, vector and level are registered outputs. Once a request is raised it holds until the CPU acknowledges it. The acknowledge marks the granted level as in service. A return strobe retires the highest level that is in service.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset `irqReq` is 0, `irqVector` is 0x00, `irqLevel` is 0 and `inService` is 0000.
- R2: Source indices are 0 = `extReq0`, 1 = `tmr0Req`, 2 = `extReq1`, 3 = `tmr1Req`, 4 = any of `uartRxReq`/`uartTxReq`/`spiReq`, and 5 = either of `t2OvfReq`/`t2ExtReq`. The vector granted for source i is 0x03 + 8*i, which gives 0x03, 0x0B, 0x13, 0x1B, 0x23 and 0x2B.
- R3: `enableReg[i]` enables source i, and `enableReg[6]` is the global enable. When the global enable is 0 no source is granted, and a source whose own bit is 0 is never granted.
- R4: The level of source i is {`prioUpper[i]`, `prioLower[i]`}, with `prioUpper` as the most significant bit. Of the eligible sources, the one at the highest level wins whatever its index.
- R5: Among eligible sources at the same level, the lowest index wins.
- R6: A source is eligible only if its level is strictly greater than every level set in `inService`. A source at an equal or lower level waits until enough levels have been retired.
- R7: While level 3 is in service, no request is raised.
- R8: On a clock edge with `intAck`=1 and `irqReq`=1, the bit of `inService` for `irqLevel` is set and `irqReq` falls.
- R9: `intRet`=1 clears the highest set bit of `inService` and leaves the lower bits unchanged.
- R10: `irqReq`, `irqVector` and `irqLevel` change on the first clock edge after a change at the inputs. While `irqReq`=1 and no acknowledge is given, all three stay stable, even if a higher-level source arrives.
- R11: `intAck` while `irqReq`=0 has no effect, and `intRet` with an empty `inService` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extReq0 | input | 1 | External request 0 flag |
| tmr0Req | input | 1 | Timer 0 flag |
| extReq1 | input | 1 | External request 1 flag |
| tmr1Req | input | 1 | Timer 1 flag |
| uartRxReq | input | 1 | Serial receive flag |
| uartTxReq | input | 1 | Serial transmit flag |
| spiReq | input | 1 | Synchronous serial flag |
| t2OvfReq | input | 1 | Timer 2 overflow flag |
| t2ExtReq | input | 1 | Timer 2 external-event flag |
| enableReg | input | 7 | Per-source enables [5:0], global enable [6] |
| prioUpper | input | 6 | Upper priority bit for each source |
| prioLower | input | 6 | Lower priority bit for each source |
| intAck | input | 1 | CPU acknowledge of the current request |
| intRet | input | 1 | Return-from-interrupt strobe |
| irqReq | output | 1 | Vectored request to the CPU |
| irqVector | output | 8 | Vector address of the granted source |
| irqLevel | output | 2 | Level of the granted source |
| inService | output | 4 | In-service mask, one bit per level |

## Verification
A change at the flags, enables or priorities shows at `irqReq`, `irqVector` and `irqLevel` one clock edge later. An acknowledge or a return updates `inService` on the edge where it is sampled. When an acknowledge or a return opens the way for a waiting source, that source's request appears one edge after the mask has changed. The bench drives its inputs 1 ns after a rising edge and reads the outputs after the next edge, or after the edge that follows. It waits two edges whenever it checks that a request stays absent.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  parameter int SRC_N    = 6;
  parameter int LVL_W    = 2;
  parameter int LVL_N    = 1 << LVL_W;
  parameter int IDX_W    = $clog2(SRC_N);
  parameter int VEC_W    = 8;
  parameter int VEC_BASE = 3;
  parameter int VEC_STEP = 8;

  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] winIdx;
    logic [LVL_W-1:0] winLvl;
    logic             take;
    logic [LVL_N-1:0] svcSet;
    logic [LVL_N-1:0] svcClr;
  } ipcStrobe_t;

  function automatic logic [VEC_W-1:0] vecOf(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction

  // true when no in-service level is at or above lvl
  function automatic logic clearAbove(input logic [LVL_N-1:0] mask,
                                      input logic [LVL_W-1:0] lvl);
    logic ok;
    ok = 1'b1;
    for (int l = 0; l < LVL_N; l++)
      if (l >= int'(lvl) && mask[l]) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
(
  input  logic [SRC_N-1:0] srcFlags,
  input  logic [SRC_N:0]   enableReg,
  input  logic [SRC_N-1:0] prioUpper,
  input  logic [SRC_N-1:0] prioLower,
  input  logic             intAck,
  input  logic             intRet,
  input  logic             reqQ,
  input  logic [LVL_W-1:0] lvlQ,
  input  logic [LVL_N-1:0] svcQ,
  output ipcStrobe_t       strobe
);
  logic [LVL_W-1:0] srcLvl [SRC_N];
  logic [SRC_N-1:0] eligible;
  logic             found;
  logic [IDX_W-1:0] bestIdx;
  logic [LVL_W-1:0] bestLvl;
  logic [LVL_N-1:0] topBit;

  genvar g;
  generate
    for (g = 0; g < SRC_N; g++) begin : g_src
      assign srcLvl[g]   = {prioUpper[g], prioLower[g]};
      assign eligible[g] = srcFlags[g] & enableReg[g] & enableReg[SRC_N]
                           & clearAbove(svcQ, srcLvl[g]);
    end
  endgenerate

  // scan from the last index down; ">=" lets lower indices win ties
  always_comb begin
    found   = 1'b0;
    bestIdx = '0;
    bestLvl = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (eligible[i] && (!found || srcLvl[i] >= bestLvl)) begin
        found   = 1'b1;
        bestIdx = IDX_W'(i);
        bestLvl = srcLvl[i];
      end
    end
  end

  always_comb begin
    topBit = '0;
    for (int l = 0; l < LVL_N; l++)
      if (svcQ[l]) topBit = LVL_N'(1) << l;
  end

  always_comb begin
    strobe.load   = !reqQ && found;
    strobe.winIdx = bestIdx;
    strobe.winLvl = bestLvl;
    strobe.take   = reqQ && intAck;
    strobe.svcSet = (reqQ && intAck) ? (LVL_N'(1) << lvlQ) : '0;
    strobe.svcClr = intRet ? topBit : '0;
  end
endmodule

// File: rtl/ipc_dp.sv
module ipc_dp
  import ipc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ipcStrobe_t       strobe,
  output logic             reqQ,
  output logic [VEC_W-1:0] vecQ,
  output logic [LVL_W-1:0] lvlQ,
  output logic [LVL_N-1:0] svcQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      vecQ <= '0;
      lvlQ <= '0;
      svcQ <= '0;
    end else begin
      svcQ <= (svcQ & ~strobe.svcClr) | strobe.svcSet;
      if (strobe.take) begin
        reqQ <= 1'b0;
      end else if (strobe.load) begin
        reqQ <= 1'b1;
        vecQ <= vecOf(strobe.winIdx);
        lvlQ <= strobe.winLvl;
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import ipc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             extReq0,
  input  logic             tmr0Req,
  input  logic             extReq1,
  input  logic             tmr1Req,
  input  logic             uartRxReq,
  input  logic             uartTxReq,
  input  logic             spiReq,
  input  logic             t2OvfReq,
  input  logic             t2ExtReq,
  input  logic [SRC_N:0]   enableReg,
  input  logic [SRC_N-1:0] prioUpper,
  input  logic [SRC_N-1:0] prioLower,
  input  logic             intAck,
  input  logic             intRet,
  output logic             irqReq,
  output logic [VEC_W-1:0] irqVector,
  output logic [LVL_W-1:0] irqLevel,
  output logic [LVL_N-1:0] inService
);
  logic [SRC_N-1:0] srcFlags;
  ipcStrobe_t       strobe;

  assign srcFlags = {t2OvfReq | t2ExtReq,
                     uartRxReq | uartTxReq | spiReq,
                     tmr1Req, extReq1, tmr0Req, extReq0};

  ipc_ctrl u_ctrl (
    .srcFlags (srcFlags),
    .enableReg(enableReg),
    .prioUpper(prioUpper),
    .prioLower(prioLower),
    .intAck   (intAck),
    .intRet   (intRet),
    .reqQ     (irqReq),
    .lvlQ     (irqLevel),
    .svcQ     (inService),
    .strobe   (strobe)
  );

  ipc_dp u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .reqQ  (irqReq),
    .vecQ  (irqVector),
    .lvlQ  (irqLevel),
    .svcQ  (inService)
  );
endmodule

// File: rtl/ipc_chk.sv
module ipc_chk
  import ipc_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             intAck,
  input logic             intRet,
  input logic             irqReq,
  input logic [VEC_W-1:0] irqVector,
  input logic [LVL_W-1:0] irqLevel,
  input logic [LVL_N-1:0] inService
);
  // R8
  ack_marks_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && intAck && !intRet) |=> (!irqReq && inService[$past(irqLevel)]));

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !intAck) |=> (irqReq && $stable(irqVector) && $stable(irqLevel)));

  // R6
  nest_above_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> clearAbove(inService, irqLevel));

  // R7
  top_level_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    inService[LVL_N-1] |-> !irqReq);

  // R11
  idle_ack_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!irqReq && !intRet) |=> $stable(inService));

  // R2
  vector_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector[2:0] == 3'd3 && irqVector < 8'h30));
endmodule

bind irq_prio_ctrl ipc_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .intAck   (intAck),
  .intRet   (intRet),
  .irqReq   (irqReq),
  .irqVector(irqVector),
  .irqLevel (irqLevel),
  .inService(inService)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] raw = '0;
  logic [6:0] en = 7'h7F;
  logic [5:0] pu = '0;
  logic [5:0] pl = '0;
  logic       ack = 1'b0;
  logic       ret = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;
  logic [1:0] irqLevel;
  logic [3:0] inService;
  int         errors = 0;
  int         checks = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rstN(rstN),
    .extReq0(raw[0]), .tmr0Req(raw[1]), .extReq1(raw[2]), .tmr1Req(raw[3]),
    .uartRxReq(raw[4]), .uartTxReq(raw[5]), .spiReq(raw[6]),
    .t2OvfReq(raw[7]), .t2ExtReq(raw[8]),
    .enableReg(en), .prioUpper(pu), .prioLower(pl),
    .intAck(ack), .intRet(ret),
    .irqReq(irqReq), .irqVector(irqVector), .irqLevel(irqLevel), .inService(inService)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic grant(input string tag, input logic [7:0] vec, input logic [1:0] lvl);
    chk({tag, " req"}, irqReq, 1);
    chk({tag, " vec"}, irqVector, vec);
    chk({tag, " lvl"}, irqLevel, lvl);
  endtask

  task automatic doReset();
    rstN = 1'b0; raw = '0; ack = 1'b0; ret = 1'b0;
    tick(); tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic pulseAck();
    ack = 1'b1; tick(); ack = 1'b0;
  endtask

  task automatic pulseRet();
    ret = 1'b1; tick(); ret = 1'b0;
  endtask

  function automatic int srcOf(input int b);
    if (b <= 3) return b;
    if (b <= 6) return 4;
    return 5;
  endfunction

  task automatic t_reset();
    en = 7'h7F; pu = '0; pl = '0;
    doReset();
    chk("R1 req", irqReq, 0);
    chk("R1 vec", irqVector, 0);
    chk("R1 lvl", irqLevel, 0);
    chk("R1 svc", inService, 0);
  endtask

  task automatic t_vectors();
    en = 7'h7F; pu = '0; pl = '0;
    for (int b = 0; b < 9; b++) begin
      doReset();
      raw = 9'(1) << b;
      tick();
      grant("R2 map", 8'(3 + 8 * srcOf(b)), 2'd0);
    end
  endtask

  task automatic t_enable();
    pu = '0; pl = '0;
    en = 7'h3F;
    doReset();
    raw = 9'h1FF;
    tick(); tick();
    chk("R3 global off", irqReq, 0);
    en = 7'h7E;
    doReset();
    raw = 9'h003;
    tick();
    grant("R3 ext0 masked", 8'h0B, 2'd0);
  endtask

  task automatic t_level();
    en = 7'h7F;
    pu = 6'b100000; pl = 6'b000001;
    doReset();
    raw = 9'h081;
    tick();
    grant("R4 t2 lvl2 over ext0 lvl1", 8'h2B, 2'd2);
    pu = 6'b001000; pl = 6'b000100;
    doReset();
    raw = 9'h00C;
    tick();
    grant("R4 upper bit is msb", 8'h1B, 2'd2);
  endtask

  task automatic t_tie();
    en = 7'h7F;
    pu = '0; pl = 6'b011100;
    doReset();
    raw = 9'h02D;
    tick();
    grant("R5 tie lvl1", 8'h13, 2'd1);
    pl = '0;
    doReset();
    raw = 9'h108;
    tick();
    grant("R5 tie lvl0", 8'h1B, 2'd0);
  endtask

  task automatic t_nest();
    en = 7'h7F;
    pu = 6'b000100; pl = 6'b001010;
    doReset();
    raw = 9'h002;
    tick();
    grant("R6 tmr0 lvl1", 8'h0B, 2'd1);
    pulseAck();
    chk("R8 svc after ack", inService, 4'b0010);
    chk("R8 req drop", irqReq, 0);
    raw = 9'h008;
    tick(); tick();
    chk("R6 equal level waits", irqReq, 0);
    raw = 9'h00C;
    tick();
    grant("R6 higher nests", 8'h13, 2'd2);
    pulseAck();
    chk("R8 svc two levels", inService, 4'b0110);
    raw = 9'h008;
    pulseRet();
    chk("R9 clear highest", inService, 4'b0010);
    tick();
    chk("R6 still waits", irqReq, 0);
    pulseRet();
    chk("R9 clear last", inService, 4'b0000);
    tick();
    grant("R6 released", 8'h1B, 2'd1);
  endtask

  task automatic t_top();
    en = 7'h7F;
    pu = 6'b000011; pl = 6'b000011;
    doReset();
    raw = 9'h001;
    tick();
    grant("R7 ext0 lvl3", 8'h03, 2'd3);
    pulseAck();
    chk("R7 svc lvl3", inService, 4'b1000);
    raw = 9'h082;
    tick(); tick();
    chk("R7 all blocked", irqReq, 0);
    pulseRet();
    chk("R9 lvl3 retired", inService, 4'b0000);
    tick();
    grant("R7 after return", 8'h0B, 2'd3);
  endtask

  task automatic t_hold();
    en = 7'h7F;
    pu = 6'b000001; pl = 6'b000001;
    doReset();
    raw = 9'h008;
    tick();
    grant("R10 tmr1 lvl0", 8'h1B, 2'd0);
    raw = 9'h009;
    tick(); tick();
    grant("R10 held", 8'h1B, 2'd0);
    pulseAck();
    chk("R8 svc lvl0", inService, 4'b0001);
    chk("R8 drop", irqReq, 0);
    tick();
    grant("R10 rearb", 8'h03, 2'd3);
  endtask

  task automatic t_ignore();
    en = 7'h7F; pu = '0; pl = '0;
    doReset();
    pulseAck();
    chk("R11 idle ack svc", inService, 0);
    chk("R11 idle ack req", irqReq, 0);
    pulseRet();
    chk("R11 empty ret", inService, 0);
  endtask

  initial begin
    t_reset();
    t_vectors();
    t_enable();
    t_level();
    t_tie();
    t_nest();
    t_top();
    t_hold();
    t_ignore();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule